// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a synchronous binary up counter of parameterised width (four bits by default). It can be cleared to zero, preset from a parallel data word, held or advanced by one on each rising clock edge. Clear and load are active-low. Both are sampled on the clock edge like the count, so no input reaches the state register without a clock.

Two count enables control counting. Counting needs both of them. The carry output goes high when the count is at its maximum value, and only the enable `cnt_thru` gates it. The other enable, `cnt_go`, has no effect on the carry. This lets counters be chained into a wider counter. Each stage's carry feeds the `cnt_thru` of the next stage, and one `cnt_go` goes to every stage. A higher stage then advances only on the cycle in which every lower stage wraps.

The operations have a fixed priority: clear first, then load, then count, then hold. Stages share a single clock and have no asynchronous reset. The first clear or load puts the state in a known value.

Top module: `presettable_counter`

## Requirements
- R1: While `clr_n` is 0 at a rising edge, the count becomes 0 on that edge, whatever `ld_n`, `cnt_go`, `cnt_thru` and `din` are.
- R2: While `clr_n` is 1 and `ld_n` is 0 at a rising edge, the count becomes `din` on that edge, whatever the enables are.
- R3: With `clr_n` and `ld_n` both 1 and both enables 1, each rising edge adds one to the count, and the maximum value (all ones) wraps to 0.
- R4: With `clr_n` and `ld_n` both 1 and either enable 0, the count keeps its value across the edge.
- R5: `carry` is 1 exactly when `cnt_thru` is 1 and the count is all ones. It follows a change of `cnt_thru` within the same cycle, and `cnt_go` has no effect on it.
- R6: On a counting edge, bit i changes only if every bit below i is 1, and bit 0 changes on every counting edge.
- R7: Changes of `clr_n`, `ld_n` or `din` between edges that are withdrawn before the next edge leave the count unchanged.
- R8: Two stages chained carry-to-`cnt_thru`, with a shared `cnt_go`, count 0 to 255 as an 8-bit value and then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_go | input | 1 | Count enable that does not affect the carry |
| cnt_thru | input | 1 | Count enable that also gates the carry output |
| din | input | WIDTH | Parallel preset value |
| cnt | output | WIDTH | Registered count |
| carry | output | 1 | High when `cnt_thru` is 1 and the count is all ones |

## Verification
The hardest situation to reach is a higher chained stage that advances at exactly the right moment. That happens only in the one cycle in which the lower stage is at all ones while both enables are high. The bench clears a two-stage chain and runs it for 256 enabled cycles, checking the combined 8-bit value every cycle, including the wrap to zero. The priority cases are reached by preloading a known value and then applying all sixteen combinations of clear, load and the two enables with a distinctive `din`.

// File: rtl/pctr_pkg.sv
package pctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } pctr_op_e;
endpackage

// File: rtl/pctr_mode_dec.sv
module pctr_mode_dec
  import pctr_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     cnt_go,
  input  logic     cnt_thru,
  output pctr_op_e op
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (!clr_n)                   op = OP_CLEAR;
    else if (!ld_n)               op = OP_LOAD;
    else if (cnt_go && cnt_thru)  op = OP_COUNT;
    else                          op = OP_HOLD;
  end
endmodule

// File: rtl/pctr_toggle_net.sv
module pctr_toggle_net #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             advance,
  output logic [WIDTH-1:0] flip
);
  // each bit flips when all lower bits are ones
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign flip[i] = advance;
    end else begin : g_upper
      assign flip[i] = advance & (&cur[i-1:0]);
    end
  end
endmodule

// File: rtl/pctr_carry.sv
module pctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             cnt_thru,
  output logic             carry
);
  assign carry = cnt_thru & (&cur);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import pctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             cnt_go,
  input  logic             cnt_thru,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             carry
);
  pctr_op_e         op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] flip;

  pctr_mode_dec u_dec (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_go   (cnt_go),
    .cnt_thru (cnt_thru),
    .op       (op)
  );

  pctr_toggle_net #(.WIDTH(WIDTH)) u_tog (
    .cur     (state_q),
    .advance (op == OP_COUNT),
    .flip    (flip)
  );

  pctr_carry #(.WIDTH(WIDTH)) u_carry (
    .cur      (state_q),
    .cnt_thru (cnt_thru),
    .carry    (carry)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_next
    always_comb begin
      unique case (op)
        OP_CLEAR: state_d[i] = 1'b0;
        OP_LOAD:  state_d[i] = din[i];
        default:  state_d[i] = state_q[i] ^ flip[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign cnt = state_q;
endmodule

// File: rtl/pctr_checker.sv
module pctr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic             cnt_go,
  input logic             cnt_thru,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] cnt,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // state is only defined once a clear or load has been taken
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= primed | ~clr_n | ~ld_n;

  logic counting;
  assign counting = clr_n && ld_n && cnt_go && cnt_thru;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> cnt == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !ld_n) |=> cnt == $past(din));

  assert_increment_R3: assert property (@(posedge clk) disable iff (!primed)
    counting |=> cnt == WIDTH'($past(cnt) + 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && !(cnt_go && cnt_thru)) |=> $stable(cnt));

  assert_carry_needs_thru_R5: assert property (@(posedge clk) disable iff (!primed)
    carry |-> (cnt_thru && cnt == ALL_ONES));

  assert_carry_at_max_R5: assert property (@(posedge clk) disable iff (!primed)
    (cnt_thru && cnt == ALL_ONES) |-> carry);

  assert_upper_stay_R6: assert property (@(posedge clk) disable iff (!primed)
    (counting && !cnt[0]) |=> cnt[WIDTH-1:1] == $past(cnt[WIDTH-1:1]));
endmodule

bind presettable_counter pctr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/presettable_counter_test.sv
module presettable_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int STAGES = 2;
  localparam int CW = W * STAGES;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         clr_n = 1'b1, ld_n = 1'b1, cnt_go = 1'b0, cnt_thru = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] cnt;
  logic         carry;

  presettable_counter #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_go(cnt_go),
    .cnt_thru(cnt_thru), .din(din), .cnt(cnt), .carry(carry)
  );

  // cascade chain
  logic          c_clr_n = 1'b1, c_ld_n = 1'b1, c_go = 1'b0;
  logic [CW-1:0] c_din = '0;
  logic [CW-1:0] c_cnt;
  logic [STAGES:0] c_link;
  assign c_link[0] = 1'b1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    presettable_counter #(.WIDTH(W)) stg (
      .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .cnt_go(c_go),
      .cnt_thru(c_link[s]), .din(c_din[s*W +: W]),
      .cnt(c_cnt[s*W +: W]), .carry(c_link[s+1])
    );
  end

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] mq = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with model comparison before and after the edge
  task automatic cyc(input logic c, input logic l, input logic p, input logic t,
                     input logic [W-1:0] dv, input string req);
    logic [W-1:0] nxt;
    @(negedge clk);
    clr_n = c; ld_n = l; cnt_go = p; cnt_thru = t; din = dv;
    #1;
    check("R5 carry", {31'd0, carry}, {31'd0, (t && mq == '1)});
    if (!c)           nxt = '0;
    else if (!l)      nxt = dv;
    else if (p && t)  nxt = W'(mq + 1'b1);
    else              nxt = mq;
    @(posedge clk);
    #1;
    mq = nxt;
    check(req, {28'd0, cnt}, {28'd0, mq});
  endtask

  task automatic t_reset_state;
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'hA, "R1 reset");
    check("R5 reset carry", {31'd0, carry}, 32'd0);
  endtask

  task automatic t_load;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h5, "R2 load 5");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hC, "R2 load over count");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'h3, "R2 load 3");
  endtask

  task automatic t_count_wrap;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'hD, "R2 preload D");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R3 count/wrap");
  endtask

  task automatic t_hold;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h6, "R2 preload 6");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'h9, "R4 go low");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'h9, "R4 thru low");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h9, "R4 both low");
  endtask

  task automatic t_toggle;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h7, "R6 preload 7");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R6 ripple to 8");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h6, "R6 preload 6");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R6 only bit0");
  endtask

  task automatic t_priority;
    for (int k = 0; k < 16; k++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h9, "R2 preload 9");
      cyc(k[3], k[2], k[1], k[0], 4'h6, k[3] ? (k[2] ? "R3 R4 combo" : "R2 combo") : "R1 combo");
    end
  endtask

  task automatic t_carry;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'hF, "R2 preload F");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R5 go no effect");
    @(negedge clk);
    cnt_go = 1'b1; cnt_thru = 1'b0; #1;
    check("R5 thru low", {31'd0, carry}, 32'd0);
    cnt_thru = 1'b1; #1;
    check("R5 same cycle", {31'd0, carry}, 32'd1);
    cnt_go = 1'b0; #1;
    check("R5 go ignored", {31'd0, carry}, 32'd1);
    cnt_thru = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, "R4 hold F");
  endtask

  task automatic t_no_async;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'hB, "R2 preload B");
    @(negedge clk);
    cnt_go = 1'b0; cnt_thru = 1'b0;
    din = 4'h2; ld_n = 1'b0; #1;
    check("R7 load mid", {28'd0, cnt}, 32'hB);
    clr_n = 1'b0; #1;
    check("R7 clear mid", {28'd0, cnt}, 32'hB);
    clr_n = 1'b1; ld_n = 1'b1; din = 4'h4;
    @(posedge clk); #1;
    check("R7 after edge", {28'd0, cnt}, 32'hB);
  endtask

  task automatic t_cascade;
    logic [CW-1:0] exp;
    @(negedge clk);
    c_clr_n = 1'b0; c_ld_n = 1'b1; c_go = 1'b1;
    @(posedge clk); #1;
    check("R8 clear", {24'd0, c_cnt}, 32'd0);
    @(negedge clk);
    c_clr_n = 1'b1; c_go = 1'b0;
    @(posedge clk); #1;
    check("R8 hold", {24'd0, c_cnt}, 32'd0);
    exp = '0;
    @(negedge clk);
    c_go = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #1;
      exp = CW'(exp + 1'b1);
      check("R8 chain", {24'd0, c_cnt}, {24'd0, exp});
    end
    check("R8 wrapped", {24'd0, c_cnt}, 32'd0);
    @(negedge clk);
    c_go = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_load();
    t_count_wrap();
    t_hold();
    t_toggle();
    t_priority();
    t_carry();
    t_no_async();
    t_cascade();
    finish_run();
  end
endmodule